// File: doc/BRIEF.md
# Three-Plane Overlay Compositor

This block lays up to three bitmap overlay planes over a stream of background video pixels, one pixel per transfer. Each plane delivers, for every pixel, a 16-bit word and a 4-bit opacity. A plane's word is either a 5/6/5 direct color or, in palette mode, an 8-bit index into a shared 256-entry table of 24-bit colors, which software loads through a simple write port. A per-plane rank field sets the stacking order. The planes are mixed onto the background from the lowest rank to the highest. The result is an 8-bit-per-channel RGB pixel, together with an active-low flag that an external mixer can use to pick the overlay over its own video.

Pixels enter and leave on valid/ready streams. A beat moves when valid and ready are both high on a rising edge. The block has three register stages that advance together, so it raises `in_ready` only when its output register is empty or the consumer is taking the current output. While `out_valid` is high and `out_ready` is low, every output stays unchanged. The sync and blank sideband bits travel with their pixel. The configuration inputs (enables, modes, ranks) are sampled on the edge that accepts a pixel.

Top module: `osd_compositor`

## Requirements
- R1: A beat is taken when `in_valid && in_ready`. `in_ready` is low while `out_valid` is high and `out_ready` is low. During such a stall `out_rgb`, the sideband bits and `out_ys_n` hold their values, and output beats leave in the order they arrived.
- R2: With `out_ready` held high, a pixel accepted on a rising edge appears on the outputs (`out_valid` high) just after the second edge that follows it. This makes three register stages in total.
- R3: In direct mode, the plane word carries red in bits [15:11], green in [10:5] and blue in [4:0]. Each field is widened to 8 bits by appending its own top bits, so 16'h8410 becomes 24'h848284.
- R4: In palette mode, the plane color is the table entry addressed by bits [7:0] of the plane word, laid out as {R[23:16],G[15:8],B[7:0]}. Bits [15:8] are ignored. A table write (`pal_wr_en`) on an edge is seen by pixels accepted on later edges.
- R5: Each plane is mixed per channel as (a*fg + (15-a)*bg + 7)/15 with integer division. So a=0 leaves the background, a=15 replaces it, and a=8 of 255 over 0 gives 136.
- R6: Plane p takes its 2-bit rank from `plane_rank[2p+1:2p]`. A higher rank is mixed later, so it lies on top. When two ranks are equal, the plane with the higher index lies on top.
- R7: A plane whose `plane_en` bit is 0 acts as opacity 0, whatever its word and opacity are.
- R8: `out_ys_n` is 0 exactly when at least one enabled plane has a nonzero opacity for that pixel.
- R9: While `rst_n` is low and right after it rises, `out_valid` is 0 and `in_ready` is 1.
- R10: `out_hsync`, `out_vsync` and `out_blank` equal the values accepted with the same pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| plane_en | input | 3 | Per-plane enable |
| plane_pal_mode | input | 3 | Per-plane format, 1 = palette index, 0 = 5/6/5 color |
| plane_rank | input | 6 | 2-bit stacking rank per plane |
| pal_wr_en | input | 1 | Palette table write strobe |
| pal_wr_addr | input | 8 | Palette entry to write |
| pal_wr_data | input | 24 | Palette color {R,G,B} |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high |
| in_bg_rgb | input | 24 | Background pixel {R,G,B} |
| in_pix | input | 48 | 16-bit word per plane, plane p at [16p+15:16p] |
| in_alpha | input | 12 | 4-bit opacity per plane, plane p at [4p+3:4p] |
| in_hsync | input | 1 | Horizontal sync bit |
| in_vsync | input | 1 | Vertical sync bit |
| in_blank | input | 1 | Blank bit |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes output beat |
| out_rgb | output | 24 | Composited pixel {R,G,B} |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_vsync | output | 1 | Delayed vertical sync |
| out_blank | output | 1 | Delayed blank |
| out_ys_n | output | 1 | Overlay-present flag, active low |

## Verification
A wrong stacking order or mixing step shows up in `out_rgb` as soon as two overlapping planes have different colors and partial opacity. Each error is visible on the very beat that leaves two edges after the one that accepted the pixel. A stage that moves while stalled, or holds while it should move, drops or repeats a beat, which breaks the arrival order seen at the output at the next transfer. A stale palette entry or a wrong rank decode appears only for pixels that use that entry or those ranks, so the stimulus swaps configuration, touches palette entries while streaming and pushes opacities to 0 and 15 often.

// File: rtl/osd_pkg.sv
package osd_pkg;
  localparam int CH_W  = 8;
  localparam int A_W   = 4;
  localparam int A_MAX = (1 << A_W) - 1;
  localparam int PIX_W = 16;
  localparam int RGB_W = 3 * CH_W;
  localparam int SUM_W = CH_W + A_W;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;

  typedef struct packed {
    rgb_t           col;
    logic [A_W-1:0] a;
  } layer_t;

  typedef struct packed {
    logic hs;
    logic vs;
    logic blank;
  } side_t;

  // 5/6/5 to 8/8/8 by repeating the top bits into the low bits
  function automatic rgb_t widen_565(input logic [PIX_W-1:0] p);
    rgb_t c;
    c.r = {p[15:11], p[15:13]};
    c.g = {p[10:5],  p[10:9]};
    c.b = {p[4:0],   p[4:2]};
    return c;
  endfunction

  // weighted mix with round-to-nearest
  function automatic logic [CH_W-1:0] mix_ch(input logic [CH_W-1:0] fg,
                                             input logic [CH_W-1:0] bg,
                                             input logic [A_W-1:0]  a);
    logic [A_W-1:0]   na;
    logic [SUM_W-1:0] s;
    na = A_W'(A_MAX) - a;
    s  = SUM_W'(a) * SUM_W'(fg) + SUM_W'(na) * SUM_W'(bg) + SUM_W'(A_MAX / 2);
    return CH_W'(s / SUM_W'(A_MAX));
  endfunction

  function automatic rgb_t mix_rgb(input rgb_t fg, input rgb_t bg,
                                   input logic [A_W-1:0] a);
    rgb_t o;
    o.r = mix_ch(fg.r, bg.r, a);
    o.g = mix_ch(fg.g, bg.g, a);
    o.b = mix_ch(fg.b, bg.b, a);
    return o;
  endfunction
endpackage

// File: rtl/osd_palette.sv
module osd_palette #(
  parameter int DEPTH = 256,
  parameter int DW    = 24,
  parameter int RP    = 3,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [RP*AW-1:0] rd_addr,
  output logic [RP*DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // one asynchronous read port per plane
  generate
    for (genvar i = 0; i < RP; i++) begin : g_rd
      assign rd_data[i*DW +: DW] = mem[rd_addr[i*AW +: AW]];
    end
  endgenerate
endmodule

// File: rtl/osd_plane_decode.sv
module osd_plane_decode
  import osd_pkg::*;
#(
  parameter int IW = 8
) (
  input  logic [PIX_W-1:0] pix,
  input  logic [A_W-1:0]   alpha,
  input  logic             enable,
  input  logic             pal_mode,
  input  logic [RGB_W-1:0] pal_color,
  output logic [IW-1:0]    pal_idx,
  output layer_t           layer
);
  assign pal_idx = pix[IW-1:0];

  always_comb begin
    layer.col = pal_mode ? rgb_t'(pal_color) : widen_565(pix);
    layer.a   = enable ? alpha : '0;
  end
endmodule

// File: rtl/osd_layer_order.sv
module osd_layer_order #(
  parameter int N  = 3,
  localparam int RW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*RW-1:0] rank,
  output logic [N*RW-1:0] level_src
);
  logic [RW-1:0] pos [N];

  // stacking position of each plane: planes below it are counted
  always_comb begin
    for (int p = 0; p < N; p++) begin
      pos[p] = '0;
      for (int q = 0; q < N; q++) begin
        if (q != p) begin
          if ((rank[q*RW +: RW] < rank[p*RW +: RW]) ||
              ((rank[q*RW +: RW] == rank[p*RW +: RW]) && (q < p)))
            pos[p] = pos[p] + RW'(1);
        end
      end
    end
  end

  // invert the permutation: which plane sits at each level
  always_comb begin
    level_src = '0;
    for (int l = 0; l < N; l++) begin
      for (int p = 0; p < N; p++) begin
        if (pos[p] == RW'(l)) level_src[l*RW +: RW] = RW'(p);
      end
    end
  end
endmodule

// File: rtl/osd_blend_unit.sv
module osd_blend_unit
  import osd_pkg::*;
(
  input  rgb_t   bg,
  input  layer_t layer,
  output rgb_t   mixed
);
  assign mixed = mix_rgb(layer.col, bg, layer.a);
endmodule

// File: rtl/osd_compositor.sv
module osd_compositor
  import osd_pkg::*;
#(
  parameter int N_PLANES  = 3,
  parameter int PAL_DEPTH = 256,
  localparam int RANK_W   = (N_PLANES > 1) ? $clog2(N_PLANES) : 1,
  localparam int PAL_AW   = $clog2(PAL_DEPTH),
  localparam int LO_CNT   = (N_PLANES + 1) / 2,
  localparam int HI_CNT   = N_PLANES - LO_CNT
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PLANES-1:0]       plane_en,
  input  logic [N_PLANES-1:0]       plane_pal_mode,
  input  logic [N_PLANES*RANK_W-1:0] plane_rank,
  input  logic                      pal_wr_en,
  input  logic [PAL_AW-1:0]         pal_wr_addr,
  input  logic [RGB_W-1:0]          pal_wr_data,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [RGB_W-1:0]          in_bg_rgb,
  input  logic [N_PLANES*PIX_W-1:0] in_pix,
  input  logic [N_PLANES*A_W-1:0]   in_alpha,
  input  logic                      in_hsync,
  input  logic                      in_vsync,
  input  logic                      in_blank,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [RGB_W-1:0]          out_rgb,
  output logic                      out_hsync,
  output logic                      out_vsync,
  output logic                      out_blank,
  output logic                      out_ys_n
);
  // pipeline control: all stages move together
  logic s1_valid, s2_valid, s3_valid;
  logic adv;
  assign adv      = !s3_valid || out_ready;
  assign in_ready = adv;

  // palette and per-plane decode
  logic [N_PLANES*PAL_AW-1:0] pal_rd_addr;
  logic [N_PLANES*RGB_W-1:0]  pal_rd_data;
  layer_t                     dec [N_PLANES];

  osd_palette #(
    .DEPTH (PAL_DEPTH),
    .DW    (RGB_W),
    .RP    (N_PLANES)
  ) palette_i (
    .clk     (clk),
    .wr_en   (pal_wr_en),
    .wr_addr (pal_wr_addr),
    .wr_data (pal_wr_data),
    .rd_addr (pal_rd_addr),
    .rd_data (pal_rd_data)
  );

  generate
    for (genvar p = 0; p < N_PLANES; p++) begin : g_dec
      osd_plane_decode #(.IW(PAL_AW)) decode_i (
        .pix       (in_pix[p*PIX_W +: PIX_W]),
        .alpha     (in_alpha[p*A_W +: A_W]),
        .enable    (plane_en[p]),
        .pal_mode  (plane_pal_mode[p]),
        .pal_color (pal_rd_data[p*RGB_W +: RGB_W]),
        .pal_idx   (pal_rd_addr[p*PAL_AW +: PAL_AW]),
        .layer     (dec[p])
      );
    end
  endgenerate

  // stacking order
  logic [N_PLANES*RANK_W-1:0] lvl_src;
  layer_t                     ordered [N_PLANES];
  logic                       any_vis;

  osd_layer_order #(.N(N_PLANES)) order_i (
    .rank      (plane_rank),
    .level_src (lvl_src)
  );

  always_comb begin
    for (int l = 0; l < N_PLANES; l++) ordered[l] = dec[lvl_src[l*RANK_W +: RANK_W]];
  end

  always_comb begin
    any_vis = 1'b0;
    for (int p = 0; p < N_PLANES; p++) any_vis = any_vis | (dec[p].a != '0);
  end

  // stage registers
  layer_t s1_lay [N_PLANES];
  rgb_t   s1_bg;
  side_t  s1_side, s2_side, s3_side;
  logic   s1_ys_n, s2_ys_n, s3_ys_n;
  rgb_t   s2_acc;
  layer_t s2_hi [HI_CNT];
  rgb_t   s3_rgb;

  // stage 2 datapath: lower levels over the background
  rgb_t lo_node [LO_CNT+1];
  assign lo_node[0] = s1_bg;
  generate
    for (genvar l = 0; l < LO_CNT; l++) begin : g_lo
      osd_blend_unit blend_lo_i (
        .bg    (lo_node[l]),
        .layer (s1_lay[l]),
        .mixed (lo_node[l+1])
      );
    end
  endgenerate

  // stage 3 datapath: upper levels
  rgb_t hi_node [HI_CNT+1];
  assign hi_node[0] = s2_acc;
  generate
    for (genvar l = 0; l < HI_CNT; l++) begin : g_hi
      osd_blend_unit blend_hi_i (
        .bg    (hi_node[l]),
        .layer (s2_hi[l]),
        .mixed (hi_node[l+1])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s2_valid <= 1'b0;
      s3_valid <= 1'b0;
    end else if (adv) begin
      s1_valid <= in_valid;
      s2_valid <= s1_valid;
      s3_valid <= s2_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      for (int l = 0; l < N_PLANES; l++) s1_lay[l] <= ordered[l];
      s1_bg   <= rgb_t'(in_bg_rgb);
      s1_side <= '{hs: in_hsync, vs: in_vsync, blank: in_blank};
      s1_ys_n <= !any_vis;

      s2_acc  <= lo_node[LO_CNT];
      for (int l = 0; l < HI_CNT; l++) s2_hi[l] <= s1_lay[LO_CNT + l];
      s2_side <= s1_side;
      s2_ys_n <= s1_ys_n;

      s3_rgb  <= hi_node[HI_CNT];
      s3_side <= s2_side;
      s3_ys_n <= s2_ys_n;
    end
  end

  assign out_valid = s3_valid;
  assign out_rgb   = s3_rgb;
  assign out_hsync = s3_side.hs;
  assign out_vsync = s3_side.vs;
  assign out_blank = s3_side.blank;
  assign out_ys_n  = s3_ys_n;
endmodule

// File: rtl/osd_compositor_chk.sv
module osd_compositor_chk
  import osd_pkg::*;
#(
  parameter int N_PLANES = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [RGB_W-1:0]        in_bg_rgb,
  input logic [N_PLANES*A_W-1:0] in_alpha,
  input logic                    in_hsync,
  input logic                    in_vsync,
  input logic                    in_blank,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [RGB_W-1:0]        out_rgb,
  input logic                    out_hsync,
  input logic                    out_vsync,
  input logic                    out_blank,
  input logic                    out_ys_n
);
  logic       fire, moves;
  logic [1:0] since_rst;
  assign fire  = in_valid && in_ready;
  assign moves = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rgb) && $stable(out_ys_n)
      && $stable({out_hsync, out_vsync, out_blank})); // R1

  AST_FULL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R1

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) && $past(fire, 3) && $past(moves, 2) && $past(moves, 1)
      |-> out_valid); // R2

  AST_SIDEBAND: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) && $past(fire, 3) && $past(moves, 2) && $past(moves, 1)
      |-> {out_hsync, out_vsync, out_blank} == $past({in_hsync, in_vsync, in_blank}, 3)); // R10

  AST_CLEAR_YS: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) && $past(fire && (in_alpha == '0), 3) && $past(moves, 2)
      && $past(moves, 1) |-> out_ys_n); // R8

  AST_CLEAR_BG: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) && $past(fire && (in_alpha == '0), 3) && $past(moves, 2)
      && $past(moves, 1) |-> out_rgb == $past(in_bg_rgb, 3)); // R5

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid && in_ready); // R9
endmodule

bind osd_compositor osd_compositor_chk #(.N_PLANES(N_PLANES)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_bg_rgb (in_bg_rgb),
  .in_alpha  (in_alpha),
  .in_hsync  (in_hsync),
  .in_vsync  (in_vsync),
  .in_blank  (in_blank),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_rgb   (out_rgb),
  .out_hsync (out_hsync),
  .out_vsync (out_vsync),
  .out_blank (out_blank),
  .out_ys_n  (out_ys_n)
);

// File: tb/osd_compositor_tb_top.sv
`timescale 1ns/1ps
module osd_compositor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  plane_en = '0, plane_pal_mode = '0;
  logic [5:0]  plane_rank = '0;
  logic        pal_wr_en = 1'b0;
  logic [7:0]  pal_wr_addr = '0;
  logic [23:0] pal_wr_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_bg_rgb = '0;
  logic [47:0] in_pix = '0;
  logic [11:0] in_alpha = '0;
  logic        in_hsync = 1'b0, in_vsync = 1'b0, in_blank = 1'b0;
  logic        out_valid, out_ready = 1'b0;
  logic [23:0] out_rgb;
  logic        out_hsync, out_vsync, out_blank, out_ys_n;

  always #10 clk = ~clk;

  osd_compositor dut_i (
    .clk(clk), .rst_n(rst_n), .plane_en(plane_en), .plane_pal_mode(plane_pal_mode),
    .plane_rank(plane_rank), .pal_wr_en(pal_wr_en), .pal_wr_addr(pal_wr_addr),
    .pal_wr_data(pal_wr_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_bg_rgb(in_bg_rgb), .in_pix(in_pix), .in_alpha(in_alpha), .in_hsync(in_hsync),
    .in_vsync(in_vsync), .in_blank(in_blank), .out_valid(out_valid), .out_ready(out_ready),
    .out_rgb(out_rgb), .out_hsync(out_hsync), .out_vsync(out_vsync), .out_blank(out_blank),
    .out_ys_n(out_ys_n)
  );

  typedef struct packed {
    logic [23:0] rgb;
    logic [2:0]  side;
    logic        ys_n;
  } exp_t;

  exp_t        q[$];
  string       tq[$];
  string       cur_req = "R1";
  logic [23:0] pal_m [256];
  int          n_chk = 0, n_fail = 0;
  logic [23:0] last_rgb;
  logic [2:0]  last_side;
  logic        last_ys;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [23:0] pal_val(input int i);
    return 24'((i * 32'h0001_0307) ^ 32'h00A5_5A3C);
  endfunction

  function automatic logic [23:0] w565(input logic [15:0] p);
    return {p[15:11], p[15:13], p[10:5], p[10:9], p[4:0], p[4:2]};
  endfunction

  function automatic logic [7:0] mix(input logic [7:0] f, input logic [7:0] b,
                                     input logic [3:0] a);
    int s;
    s = int'(a) * int'(f) + (15 - int'(a)) * int'(b) + 7;
    return 8'(s / 15);
  endfunction

  function automatic exp_t model();
    exp_t        e;
    logic [23:0] acc, col;
    logic [3:0]  a;
    int          pos [3];
    bit          vis;
    acc = in_bg_rgb;
    vis = 0;
    for (int p = 0; p < 3; p++) begin
      pos[p] = 0;
      for (int k = 0; k < 3; k++)
        if (k != p && (plane_rank[2*k +: 2] < plane_rank[2*p +: 2] ||
            (plane_rank[2*k +: 2] == plane_rank[2*p +: 2] && k < p))) pos[p]++;
    end
    for (int l = 0; l < 3; l++) begin
      for (int p = 0; p < 3; p++) begin
        if (pos[p] == l) begin
          col = plane_pal_mode[p] ? pal_m[in_pix[16*p +: 8]] : w565(in_pix[16*p +: 16]);
          a   = plane_en[p] ? in_alpha[4*p +: 4] : 4'd0;
          if (a != 0) vis = 1;
          acc = {mix(col[23:16], acc[23:16], a), mix(col[15:8], acc[15:8], a),
                 mix(col[7:0], acc[7:0], a)};
        end
      end
    end
    e.rgb  = acc;
    e.side = {in_hsync, in_vsync, in_blank};
    e.ys_n = !vis;
    return e;
  endfunction

  // one clock: drive at the falling edge, observe, then pass the rising edge
  task automatic step(input logic v, input logic rdy);
    exp_t  e;
    string t;
    @(negedge clk);
    in_valid  = v;
    out_ready = rdy;
    #1;
    if (out_valid && out_ready) begin
      if (q.size() == 0) chk(0, "R1", "unexpected output beat", 32'd1, 32'd0);
      else begin
        e = q.pop_front();
        t = tq.pop_front();
        chk(out_rgb == e.rgb, t, "rgb", 32'(out_rgb), 32'(e.rgb));
        chk({out_hsync, out_vsync, out_blank} == e.side, "R10", "sideband",
            32'({out_hsync, out_vsync, out_blank}), 32'(e.side));
        chk(out_ys_n == e.ys_n, "R8", "ys_n", 32'(out_ys_n), 32'(e.ys_n));
        last_rgb  = out_rgb;
        last_side = {out_hsync, out_vsync, out_blank};
        last_ys   = out_ys_n;
      end
    end
    if (in_valid && in_ready) begin
      q.push_back(model());
      tq.push_back(cur_req);
    end
    @(posedge clk);
    #1;
    if (pal_wr_en) pal_m[pal_wr_addr] = pal_wr_data;
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && (q.size() != 0 || out_valid); i++) step(1'b0, 1'b1);
    chk(q.size() == 0, cur_req, "beats lost", 32'(q.size()), 32'd0);
  endtask

  task automatic single();
    step(1'b1, 1'b1);
    in_valid = 1'b0;
    drain();
  endtask

  function automatic logic [3:0] rnd_alpha();
    case ($urandom % 4)
      0:       return 4'd0;
      1:       return 4'd15;
      default: return 4'($urandom);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R2", "watchdog expired", 32'd0, 32'd1);
    finish_up();
  end

  initial begin
    int          lat;
    logic [23:0] hold_rgb;
    void'($urandom(32'd20240611));

    // R9: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R9", "out_valid in reset", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R9", "in_ready in reset", 32'(in_ready), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R9", "out_valid after reset", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R9", "in_ready after reset", 32'(in_ready), 32'd1);

    // load the palette
    for (int i = 0; i < 256; i++) begin
      pal_wr_en = 1'b1; pal_wr_addr = 8'(i); pal_wr_data = pal_val(i);
      step(1'b0, 1'b1);
    end
    pal_wr_en = 1'b0;

    // R3: 5/6/5 widening
    cur_req = "R3";
    plane_en = 3'b001; plane_pal_mode = 3'b000; plane_rank = 6'b10_01_00;
    in_bg_rgb = 24'h000000; in_pix = {32'h0, 16'h8410}; in_alpha = 12'h00F;
    single();
    chk(last_rgb == 24'h848284, "R3", "widened color", 32'(last_rgb), 32'h848284);

    // R5: half mix and clear plane
    cur_req = "R5";
    in_pix = {32'h0, 16'hFFFF}; in_alpha = 12'h008;
    single();
    chk(last_rgb == 24'h888888, "R5", "alpha 8 mix", 32'(last_rgb), 32'h888888);
    in_bg_rgb = 24'h123456; in_alpha = 12'h000;
    single();
    chk(last_rgb == 24'h123456, "R5", "alpha 0 keeps bg", 32'(last_rgb), 32'h123456);
    chk(last_ys == 1'b1, "R8", "no overlay flag", 32'(last_ys), 32'd1);

    // R4: palette index from low byte only
    cur_req = "R4";
    plane_pal_mode = 3'b001; in_pix = {32'h0, 16'hAB37}; in_alpha = 12'h00F;
    single();
    chk(last_rgb == pal_val(8'h37), "R4", "palette color", 32'(last_rgb), 32'(pal_val(8'h37)));
    // write and accept on the same edge: old entry, then new entry
    pal_wr_en = 1'b1; pal_wr_addr = 8'h37; pal_wr_data = 24'h0F1E2D;
    step(1'b1, 1'b1);
    pal_wr_en = 1'b0;
    step(1'b1, 1'b1);
    in_valid = 1'b0;
    drain();
    chk(last_rgb == 24'h0F1E2D, "R4", "rewritten entry", 32'(last_rgb), 32'h0F1E2D);

    // R7: disabled planes ignored
    cur_req = "R7";
    plane_en = 3'b000; plane_pal_mode = 3'b000; in_pix = 48'hF800_07E0_001F;
    in_alpha = 12'hFFF; in_bg_rgb = 24'h405060;
    single();
    chk(last_rgb == 24'h405060, "R7", "disabled planes", 32'(last_rgb), 32'h405060);
    chk(last_ys == 1'b1, "R7", "disabled ys_n", 32'(last_ys), 32'd1);

    // R6: stacking order
    cur_req = "R6";
    plane_en = 3'b011; in_alpha = 12'h0FF; in_pix = 48'h0000_F800_001F;
    plane_rank = 6'b00_01_10;
    single();
    chk(last_rgb == 24'h0000FF, "R6", "plane0 on top", 32'(last_rgb), 32'h0000FF);
    plane_rank = 6'b00_10_01;
    single();
    chk(last_rgb == 24'hFF0000, "R6", "plane1 on top", 32'(last_rgb), 32'hFF0000);
    plane_rank = 6'b00_00_00;
    single();
    chk(last_rgb == 24'hFF0000, "R6", "tie: higher index on top", 32'(last_rgb), 32'hFF0000);

    // R8: faint plane sets the flag
    cur_req = "R8";
    plane_en = 3'b100; in_alpha = 12'h100;
    single();
    chk(last_ys == 1'b0, "R8", "overlay flag", 32'(last_ys), 32'd0);

    // R10: sideband carried
    cur_req = "R10";
    in_hsync = 1'b1; in_vsync = 1'b0; in_blank = 1'b1;
    single();
    chk(last_side == 3'b101, "R10", "sideband", 32'(last_side), 32'b101);
    in_hsync = 1'b0; in_blank = 1'b0;

    // R2: latency
    cur_req = "R2";
    step(1'b1, 1'b1);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 10) begin
      @(posedge clk);
      #1;
      lat++;
    end
    chk(lat == 3, "R2", "latency in edges", 32'(lat), 32'd3);
    drain();

    // R1: back-pressure
    cur_req = "R1";
    for (int i = 0; i < 3; i++) begin
      in_bg_rgb = 24'(i * 32'h111111);
      step(1'b1, 1'b0);
    end
    @(negedge clk);
    #1;
    chk(in_ready == 1'b0, "R1", "in_ready when full", 32'(in_ready), 32'd0);
    hold_rgb = out_rgb;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    chk(out_rgb == hold_rgb, "R1", "output held", 32'(out_rgb), 32'(hold_rgb));
    chk(q.size() == 3, "R1", "beats in flight", 32'(q.size()), 32'd3);
    in_valid = 1'b0;
    drain();

    // random traffic
    cur_req = "R6";
    for (int i = 0; i < 4000; i++) begin
      if (i % 200 == 0) begin
        plane_en = 3'($urandom); plane_pal_mode = 3'($urandom);
        plane_rank = 6'($urandom);
      end
      pal_wr_en = ($urandom % 10) == 0;
      pal_wr_addr = 8'($urandom); pal_wr_data = 24'($urandom);
      in_bg_rgb = 24'($urandom);
      in_pix = {16'($urandom), 16'($urandom), 16'($urandom)};
      in_alpha = {rnd_alpha(), rnd_alpha(), rnd_alpha()};
      in_hsync = 1'($urandom); in_vsync = 1'($urandom); in_blank = 1'($urandom);
      step(($urandom % 4) != 0, ($urandom % 10) < 7);
    end
    pal_wr_en = 1'b0;
    in_valid = 1'b0;
    drain();

    finish_up();
  end
endmodule